// File: doc/BRIEF.md
# Differential Output Enable Controller

This block decides, for each of twelve differential clock output pairs, whether the pair drives a normal clock, is parked by a global power-down, or floats at high impedance. Two enable sources feed each pair: an active-low enable pin and an enable bit held in the serial-bus register file. The last two pairs have only one pin between them. A power-down pin overrides both sources. While it is active, a register bit selects whether the true leg of every pair is driven at a boosted reference current or left floating. The complement leg is always held low. The result is one 2-bit state code per pair, which the analog output drivers decode.

The block also supplies the read-only register bytes that report enable pin levels to software. It latches three configuration straps once, on the first clock after reset, and reports them in the upper bits of one status byte. A counter measures the time since power-down was released and raises a stable flag once the drivers have had time to settle. All asynchronous pins pass through a synchronizer before any of this logic uses them.

Top module: `diff_oe_ctrl`

## Requirements
- R1: Pairs 10 and 11 both take their pin enable from the shared pin `oe_pin_n[10]`. With equal register enable bits, the two pairs always carry the same state.
- R2: A pair's state is 2'b01 (normal) when synchronized power-down is low, its synchronized pin is low and its register bit `reg_en[p]` is 1.
- R3: With power-down low, a pair whose pin is high or whose register bit is 0 takes state 2'b00 (high impedance). The code 2'b11 never appears.
- R4: While synchronized power-down is high, every pair takes state 2'b10 (parked), whatever its pin or register bit.
- R5: `park_true_drive` is 1 exactly when synchronized power-down is high and `park_mode` is 1. It has the same latency as the pair states.
- R6: `rb_oe_lo` bit k reports the synchronized level of `oe_pin_n[k]` for k = 0 to 7. A 1 means disabled.
- R7: `rb_oe_hi` bits 0, 1 and 2 report `oe_pin_n[8]`, `oe_pin_n[9]` and the shared pin `oe_pin_n[10]`. Bits 3 and 4 read 0.
- R8: `rb_oe_hi` bits 5, 6 and 7 hold `strap_in[0]` (PLL bypass), `strap_in[1]` (bandwidth) and `strap_in[2]` (frequency select), captured on the first clock after reset. Later changes on `strap_in` have no effect.
- R9: `outputs_stable` is 0 while power-down is active. It rises STABLE_CYCLES+2 clock edges after the edge that first samples the power-down pin low, and it falls 3 edges after the pin is sampled high.
- R10: During reset, all pair states are 2'b00, `park_true_drive` and `outputs_stable` are 0, `rb_oe_lo` reads 8'hFF and `rb_oe_hi` reads 8'h07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_pin_n | input | 11 | Active-low enable pins; bit 10 is shared by pairs 10 and 11 |
| pwrdn_pin | input | 1 | Asynchronous power-down request, active high |
| reg_en | input | 12 | Register enable bit per pair, 1 = enabled |
| park_mode | input | 1 | Park choice during power-down: 1 = true leg driven, 0 = floating |
| strap_in | input | 3 | Configuration straps: bypass, bandwidth, frequency select |
| pair_state | output | 24 | Two bits per pair, pair p at bits 2p+1:2p |
| park_true_drive | output | 1 | Enable for the boosted true-leg current during power-down |
| rb_oe_lo | output | 8 | Readback of enable pins 0 to 7 |
| rb_oe_hi | output | 8 | Readback of pins 8, 9 and the shared pin, plus the latched straps |
| outputs_stable | output | 1 | High once the settle time after power-down has elapsed |

## Verification
Each result has its own latency. Pin and power-down changes reach the pair states and `park_true_drive` three edges after they are first sampled. A change on `reg_en` or `park_mode` appears one edge later. The readback bytes follow the pins two edges after sampling. The stable flag rises STABLE_CYCLES+2 edges after power-down is released. The bench model keeps a two-entry history of sampled pin values and applies each register input at the edge where it is sampled. It is updated on every rising edge and compared with the outputs on the following falling edge, so every expected value lines up with the cycle in which the design registers it.

// File: rtl/doe_pkg.sv
`timescale 1ns/1ps
package doe_pkg;
   localparam int PS_W = 2;
   typedef enum logic [PS_W-1:0] {
      PS_HIZ  = 2'b00,
      PS_RUN  = 2'b01,
      PS_PARK = 2'b10
   } pair_state_e;
endpackage

// File: rtl/doe_sync.sv
`timescale 1ns/1ps
module doe_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/doe_strap_latch.sv
`timescale 1ns/1ps
module doe_strap_latch #(
   parameter int WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] strap_in,
   output logic [WIDTH-1:0] strap_q,
   output logic             done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_q <= '0;
         done    <= 1'b0;
      end else if (!done) begin
         strap_q <= strap_in;
         done    <= 1'b1;
      end
   end
endmodule

// File: rtl/doe_pair_ctrl.sv
`timescale 1ns/1ps
module doe_pair_ctrl
   import doe_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pd,
   input  logic        oe_n,
   input  logic        en,
   output pair_state_e state
);
   pair_state_e nxt;

   always_comb begin
      if (pd)               nxt = PS_PARK;
      else if (!oe_n && en) nxt = PS_RUN;
      else                  nxt = PS_HIZ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_HIZ;
      else        state <= nxt;
   end
endmodule

// File: rtl/doe_stable_timer.sv
`timescale 1ns/1ps
module doe_stable_timer #(
   parameter int LIMIT = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic stable
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (hold)           cnt <= '0;
      else if (cnt != LIMIT_C) cnt <= cnt + 1'b1;
   end

   assign stable = (cnt == LIMIT_C);
endmodule

// File: rtl/diff_oe_ctrl.sv
`timescale 1ns/1ps
module diff_oe_ctrl
   import doe_pkg::*;
#(
   parameter int NUM_PAIRS     = 12,
   parameter int SYNC_STAGES   = 2,
   parameter int STABLE_CYCLES = 250000,
   parameter int STRAP_W       = 3,
   localparam int NUM_PINS     = NUM_PAIRS - 1,
   localparam int HI_PINS      = NUM_PINS - 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PINS-1:0]       oe_pin_n,
   input  logic                      pwrdn_pin,
   input  logic [NUM_PAIRS-1:0]      reg_en,
   input  logic                      park_mode,
   input  logic [STRAP_W-1:0]        strap_in,
   output logic [NUM_PAIRS*PS_W-1:0] pair_state,
   output logic                      park_true_drive,
   output logic [7:0]                rb_oe_lo,
   output logic [7:0]                rb_oe_hi,
   output logic                      outputs_stable
);
   if (NUM_PAIRS < 10 || NUM_PAIRS > 12) begin : g_bad_pairs
      $error("NUM_PAIRS must lie in 10..12 to fit the readback bytes");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STRAP_W != 3) begin : g_bad_strap
      $error("STRAP_W must be 3");
   end
   if (STABLE_CYCLES < 1) begin : g_bad_limit
      $error("STABLE_CYCLES must be positive");
   end

   logic [NUM_PINS:0]    sync_q;
   logic [NUM_PINS-1:0]  oe_s;
   logic                 pd_s;
   logic [STRAP_W-1:0]   strap_q;
   logic                 strap_done;

   // Pins and power-down share one synchronizer; reset value is "disabled, powered down".
   doe_sync #(
      .WIDTH   (NUM_PINS + 1),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({(NUM_PINS + 1){1'b1}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pwrdn_pin, oe_pin_n}),
      .q     (sync_q)
   );

   assign oe_s = sync_q[NUM_PINS-1:0];
   assign pd_s = sync_q[NUM_PINS];

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      localparam int PIN = (p < NUM_PINS) ? p : NUM_PINS - 1;
      pair_state_e st;
      doe_pair_ctrl u_pair (
         .clk   (clk),
         .rst_n (rst_n),
         .pd    (pd_s),
         .oe_n  (oe_s[PIN]),
         .en    (reg_en[p]),
         .state (st)
      );
      assign pair_state[PS_W*p +: PS_W] = st;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) park_true_drive <= 1'b0;
      else        park_true_drive <= pd_s & park_mode;
   end

   doe_strap_latch #(.WIDTH(STRAP_W)) u_strap (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_in (strap_in),
      .strap_q  (strap_q),
      .done     (strap_done)
   );

   doe_stable_timer #(.LIMIT(STABLE_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (pd_s),
      .stable (outputs_stable)
   );

   always_comb begin
      rb_oe_lo              = oe_s[7:0];
      rb_oe_hi              = '0;
      rb_oe_hi[HI_PINS-1:0] = oe_s[NUM_PINS-1:8];
      rb_oe_hi[7:5]         = strap_q;
   end
endmodule

// File: rtl/doe_checker.sv
`timescale 1ns/1ps
module doe_checker #(
   parameter int NUM_PAIRS = 12,
   localparam int NUM_PINS = NUM_PAIRS - 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   pd_s,
   input logic [NUM_PINS-1:0]    oe_s,
   input logic [NUM_PAIRS-1:0]   reg_en,
   input logic [NUM_PAIRS*2-1:0] pair_state,
   input logic                   outputs_stable,
   input logic                   strap_done,
   input logic [4:0]             rb_upper
);
   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      localparam int PIN = (p < NUM_PINS) ? p : NUM_PINS - 1;
      AST_PAIR_RUN: assert property (@(posedge clk) disable iff (!rst_n)
         (!pd_s && !oe_s[PIN] && reg_en[p]) |=> pair_state[2*p +: 2] == 2'b01); // R2
      AST_PAIR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
         (!pd_s && (oe_s[PIN] || !reg_en[p])) |=> pair_state[2*p +: 2] == 2'b00); // R3
      AST_PAIR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
         pd_s |=> pair_state[2*p +: 2] == 2'b10); // R4
      AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
         pair_state[2*p +: 2] != 2'b11); // R3
   end

   AST_SHARED_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_en[NUM_PAIRS-1] == reg_en[NUM_PAIRS-2])
      |=> pair_state[2*(NUM_PAIRS-1) +: 2] == pair_state[2*(NUM_PAIRS-2) +: 2]); // R1
   AST_PD_UNSTABLE: assert property (@(posedge clk) disable iff (!rst_n)
      pd_s |=> !outputs_stable); // R9
   AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      strap_done |=> $stable(rb_upper[4:2])); // R8
   AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rb_upper[1:0] == 2'b00); // R7
endmodule

bind diff_oe_ctrl doe_checker #(.NUM_PAIRS(NUM_PAIRS)) u_doe_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .pd_s           (pd_s),
   .oe_s           (oe_s),
   .reg_en         (reg_en),
   .pair_state     (pair_state),
   .outputs_stable (outputs_stable),
   .strap_done     (strap_done),
   .rb_upper       (rb_oe_hi[7:3])
);

// File: tb/diff_oe_ctrl_bench.sv
`timescale 1ns/1ps
module diff_oe_ctrl_bench;
   localparam int NP   = 12;
   localparam int NPIN = NP - 1;
   localparam int LIM  = 40;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NPIN-1:0] oe_pin_n = '1;
   logic            pwrdn_pin = 1'b1;
   logic [NP-1:0]   reg_en = '1;
   logic            park_mode = 1'b1;
   logic [2:0]      strap_in = 3'b101;
   logic [NP*2-1:0] pair_state;
   logic            park_true_drive;
   logic [7:0]      rb_oe_lo;
   logic [7:0]      rb_oe_hi;
   logic            outputs_stable;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   diff_oe_ctrl #(.NUM_PAIRS(NP), .STABLE_CYCLES(LIM)) u_diff_oe_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .oe_pin_n        (oe_pin_n),
      .pwrdn_pin       (pwrdn_pin),
      .reg_en          (reg_en),
      .park_mode       (park_mode),
      .strap_in        (strap_in),
      .pair_state      (pair_state),
      .park_true_drive (park_true_drive),
      .rb_oe_lo        (rb_oe_lo),
      .rb_oe_hi        (rb_oe_hi),
      .outputs_stable  (outputs_stable)
   );

   // Reference model: history of sampled {pd, pins}, oldest first.
   logic [NPIN:0] hist[$];
   logic [1:0]    m_st[NP];
   logic          m_park = 1'b0;
   int            m_cnt = 0;
   logic [2:0]    m_strap = '0;
   bit            m_got = 1'b0;
   logic          m_pd_used = 1'b1;

   initial begin
      hist.push_back('1);
      hist.push_back('1);
      for (int p = 0; p < NP; p++) m_st[p] = 2'b00;
   end

   always @(posedge clk) begin : model
      logic [NPIN:0] old;
      if (!rst_n) begin
         hist.delete();
         hist.push_back('1);
         hist.push_back('1);
         for (int p = 0; p < NP; p++) m_st[p] = 2'b00;
         m_park = 1'b0; m_cnt = 0; m_strap = '0; m_got = 1'b0; m_pd_used = 1'b1;
      end else begin
         old = hist[0];
         m_pd_used = old[NPIN];
         for (int p = 0; p < NP; p++) begin
            int pin;
            pin = (p < NPIN) ? p : NPIN - 1;
            if (old[NPIN])                   m_st[p] = 2'b10;
            else if (!old[pin] && reg_en[p]) m_st[p] = 2'b01;
            else                             m_st[p] = 2'b00;
         end
         m_park = old[NPIN] & park_mode;
         if (old[NPIN])      m_cnt = 0;
         else if (m_cnt < LIM) m_cnt++;
         if (!m_got) begin m_strap = strap_in; m_got = 1'b1; end
         void'(hist.pop_front());
         hist.push_back({pwrdn_pin, oe_pin_n});
      end
   end

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic string pair_tag(int p, logic [1:0] e);
      if (!rst_n)            return "R10";
      if (m_pd_used)         return "R4";
      if (p >= NPIN - 1)     return "R1";
      if (e == 2'b01)        return "R2";
      return "R3";
   endfunction

   always @(negedge clk) begin
      if (!done) begin
         for (int p = 0; p < NP; p++)
            chk(pair_tag(p, m_st[p]), $sformatf("pair %0d state", p),
                32'(pair_state[2*p +: 2]), 32'(m_st[p]));
         chk("R5", "park_true_drive", 32'(park_true_drive), 32'(m_park));
         chk("R6", "rb_oe_lo", 32'(rb_oe_lo), 32'(hist[0][7:0]));
         chk("R7", "rb_oe_hi pins", 32'(rb_oe_hi[4:0]), 32'({2'b00, hist[0][NPIN-1:8]}));
         chk("R8", "rb_oe_hi straps", 32'(rb_oe_hi[7:5]), 32'(m_strap));
         chk("R9", "outputs_stable", 32'(outputs_stable), 32'(m_cnt == LIM));
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      cyc(5);
      // R10: reset values
      chk("R10", "reset pair states", 32'(pair_state), 32'd0);
      chk("R10", "reset stable", 32'(outputs_stable), 32'd0);
      chk("R10", "reset rb_oe_hi", 32'(rb_oe_hi), 32'h07);
      rst_n = 1'b1;
      cyc(3);
      strap_in = 3'b010;            // R8: must be ignored
      cyc(4);
      chk("R8", "strap capture", 32'(rb_oe_hi[7:5]), 32'h5);
      pwrdn_pin = 1'b0;             // R9: settle count starts
      cyc(LIM + 10);
      chk("R9", "stable after settle", 32'(outputs_stable), 32'd1);
      oe_pin_n = '0;                // R2: all normal
      cyc(5);
      reg_en = 12'hA5A;             // R3: register disables
      cyc(4);
      reg_en = '1;
      oe_pin_n[10] = 1'b1;          // R1: shared pin drops pairs 10 and 11
      cyc(4);
      oe_pin_n[10] = 1'b0;
      reg_en[11] = 1'b0;            // R1: only pair 11 off
      cyc(4);
      reg_en = '1;
      for (int k = 0; k < NPIN; k++) begin   // R6 and R7: walking disable
         oe_pin_n = '0;
         oe_pin_n[k] = 1'b1;
         cyc(3);
      end
      oe_pin_n = '0;
      park_mode = 1'b0;             // R4 and R5: park floating
      pwrdn_pin = 1'b1;
      cyc(6);
      park_mode = 1'b1;             // R5: park driven
      cyc(4);
      pwrdn_pin = 1'b0;             // R9: short release then re-entry
      cyc(10);
      pwrdn_pin = 1'b1;
      cyc(5);
      pwrdn_pin = 1'b0;
      cyc(LIM + 5);
      for (int i = 0; i < 300; i++) begin
         oe_pin_n  = NPIN'($urandom);
         reg_en    = NP'($urandom);
         park_mode = 1'($urandom);
         pwrdn_pin = (($urandom % 16) == 0);
         strap_in  = 3'($urandom);  // R8: still ignored
         cyc(1 + ($urandom % 3));
      end
      pwrdn_pin = 1'b0;
      cyc(LIM + 5);
      finish_run();
   end
endmodule